// File: doc/BRIEF.md
# External Interrupt Sense Unit

This block watches eight external interrupt pins and turns activity on them into per-pin interrupt requests. Each pin carries a 2-bit sense mode: a low level on the pin, any change of its value, only a high-to-low transition, or only a low-to-high transition. Pins are brought into the system clock domain through a two-stage synchronizer. A further sample register keeps the previous synchronized value, so an edge is seen as a difference between two consecutive clocked samples.

Edge modes set a sticky flag per pin. Software clears a flag by writing a one to its bit. Low-level mode keeps no flag: its request follows the synchronized pin and lasts only while the pin stays low. A per-pin mask and a global enable input gate the requests onto the pending vector and the single interrupt line. Software reaches the sense, mask and flag registers through a small register bus. Software should clear a pin's mask bit before it changes that pin's mode, because the change itself can look like an edge.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset, both sense registers, the mask and the flags read 0, the pending vector is 0 and the interrupt line is low. The synchronizer and sample registers start in the pin-high state.
- R2: Address 0 holds the modes of pins 3..0 and address 1 holds the modes of pins 4..7. Pin n uses bits 2(n mod 4)+1 : 2(n mod 4) of its register. Address 2 is the mask (bit n for pin n) and address 3 is the flag register. Written values read back unchanged.
- R3: In mode 00 (low level), a pin held low drives its request two clock edges after the change. The request drops the same way once the pin returns high, and no flag bit is ever set.
- R4: In mode 01 (any change), both a falling and a rising transition set the pin's flag.
- R5: In mode 10 (falling edge), a high-to-low transition sets the flag and a low-to-high transition leaves it unchanged. A low pulse lasting one clock period is caught.
- R6: In mode 11 (rising edge), a low-to-high transition sets the flag and a high-to-low transition leaves it unchanged.
- R7: An edge-mode flag becomes visible three rising clock edges after the pin changes (two synchronizer stages plus one sample stage), and not at two.
- R8: Writing address 3 clears every flag whose data bit is 1. Bits written as 0 keep their flag.
- R9: When a new edge on a pin and a clearing write to its flag land in the same cycle, the flag stays set.
- R10: A flag is recorded even when its mask bit is 0, but it shows on neither the pending vector nor the interrupt line until the mask bit is set.
- R11: With the global enable low, the pending vector is 0 and the interrupt line is low, whatever the flags and levels are.
- R12: The interrupt line is high exactly when at least one bit of the pending vector is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 8 | External interrupt pins, asynchronous |
| glb_en_i | input | 1 | Global interrupt enable |
| bus_addr_i | input | 2 | Register address |
| bus_we_i | input | 1 | Register write strobe |
| bus_wdata_i | input | 8 | Register write data |
| bus_rdata_o | output | 8 | Register read data for the current address |
| pending_o | output | 8 | Masked, enabled request per pin |
| irq_o | output | 1 | OR of the pending vector |

## Verification
Each of the four modes is driven with both a falling and a rising transition on its own pin. This shows that each mode reacts to the right direction and ignores the other. The low-level pin is held low and then released, which separates a live request from a latched one. The flag register is read back to confirm that no flag was stored. Flag timing is sampled one cycle before and at the expected edge, and a one-period pulse checks that short activity is still caught. A clearing write is placed in the same cycle as a fresh edge, and the mask and global enable are toggled while requests are present. Together these show which gate drops which request.

// File: rtl/exti_pkg.sv
package exti_pkg;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_ANY  = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } sense_e;

    localparam int MODE_W       = 2;
    localparam int PINS_PER_REG = 4;

endpackage

// File: rtl/exti_sync.sv
module exti_sync #(
    parameter int NUM_PINS = 8,
    parameter int STAGES   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_i,
    output logic [NUM_PINS-1:0] cur_o,
    output logic [NUM_PINS-1:0] prev_o
);

    typedef struct packed {
        logic [STAGES-1:0][NUM_PINS-1:0] chain;
        logic [NUM_PINS-1:0]             prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d          = sync_q;
        sync_d.chain[0] = pin_i;
        for (int s = 1; s < STAGES; s++) begin
            sync_d.chain[s] = sync_q.chain[s-1];
        end
        sync_d.prev = sync_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign cur_o  = sync_q.chain[STAGES-1];
    assign prev_o = sync_q.prev;

endmodule

// File: rtl/exti_edge.sv
module exti_edge
    import exti_pkg::*;
(
    input  sense_e mode_i,
    input  logic   cur_i,
    input  logic   prev_i,
    output logic   evt_o,
    output logic   lvl_o
);

    always_comb begin
        evt_o = 1'b0;
        lvl_o = 1'b0;
        unique case (mode_i)
            SENSE_LOW:  lvl_o = ~cur_i;
            SENSE_ANY:  evt_o = cur_i ^ prev_i;
            SENSE_FALL: evt_o = prev_i & ~cur_i;
            SENSE_RISE: evt_o = ~prev_i & cur_i;
            default:    evt_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/exti_regs.sv
module exti_regs
    import exti_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int N_SENSE  = NUM_PINS / PINS_PER_REG,
    parameter int ADDR_W   = $clog2(N_SENSE + 2)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [ADDR_W-1:0]            addr_i,
    input  logic                         we_i,
    input  logic [NUM_PINS-1:0]          wdata_i,
    input  logic [NUM_PINS-1:0]          evt_i,
    output logic [NUM_PINS-1:0]          rdata_o,
    output logic [MODE_W*NUM_PINS-1:0]   sense_o,
    output logic [NUM_PINS-1:0]          mask_o,
    output logic [NUM_PINS-1:0]          flag_o
);

    localparam int DATA_W = NUM_PINS;
    localparam logic [ADDR_W-1:0] MASK_ADDR = ADDR_W'(N_SENSE);
    localparam logic [ADDR_W-1:0] FLAG_ADDR = ADDR_W'(N_SENSE + 1);

    typedef struct packed {
        logic [N_SENSE-1:0][DATA_W-1:0] sense;
        logic [DATA_W-1:0]              mask;
        logic [DATA_W-1:0]              flags;
    } regs_t;

    regs_t regs_d, regs_q;
    logic [DATA_W-1:0] clr_bits;

    always_comb begin
        regs_d = regs_q;
        for (int r = 0; r < N_SENSE; r++) begin
            if (we_i && addr_i == ADDR_W'(r)) begin
                regs_d.sense[r] = wdata_i;
            end
        end
        if (we_i && addr_i == MASK_ADDR) begin
            regs_d.mask = wdata_i;
        end
        clr_bits     = (we_i && addr_i == FLAG_ADDR) ? wdata_i : '0;
        regs_d.flags = (regs_q.flags & ~clr_bits) | evt_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        for (int r = 0; r < N_SENSE; r++) begin
            if (addr_i == ADDR_W'(r)) begin
                rdata_o = regs_q.sense[r];
            end
        end
        if (addr_i == MASK_ADDR) rdata_o = regs_q.mask;
        if (addr_i == FLAG_ADDR) rdata_o = regs_q.flags;
    end

    assign sense_o = regs_q.sense;
    assign mask_o  = regs_q.mask;
    assign flag_o  = regs_q.flags;

endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
    import exti_pkg::*;
#(
    parameter int NUM_PINS    = 8,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic                glb_en_i,
    input  logic [ADDR_W-1:0]   bus_addr_i,
    input  logic                bus_we_i,
    input  logic [NUM_PINS-1:0] bus_wdata_i,
    output logic [NUM_PINS-1:0] bus_rdata_o,
    output logic [NUM_PINS-1:0] pending_o,
    output logic                irq_o
);

    localparam int N_SENSE = NUM_PINS / PINS_PER_REG;
    localparam logic [ADDR_W-1:0] FLAG_ADDR = ADDR_W'(N_SENSE + 1);

    logic [NUM_PINS-1:0]        cur_vec;
    logic [NUM_PINS-1:0]        prev_vec;
    logic [NUM_PINS-1:0]        evt_vec;
    logic [NUM_PINS-1:0]        lvl_vec;
    logic [NUM_PINS-1:0]        mask_q;
    logic [NUM_PINS-1:0]        flag_q;
    logic [MODE_W*NUM_PINS-1:0] sense_vec;

    exti_sync #(
        .NUM_PINS (NUM_PINS),
        .STAGES   (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_i),
        .cur_o  (cur_vec),
        .prev_o (prev_vec)
    );

    for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
        exti_edge u_edge (
            .mode_i (sense_e'(sense_vec[MODE_W*n +: MODE_W])),
            .cur_i  (cur_vec[n]),
            .prev_i (prev_vec[n]),
            .evt_o  (evt_vec[n]),
            .lvl_o  (lvl_vec[n])
        );
    end

    exti_regs #(
        .NUM_PINS (NUM_PINS),
        .N_SENSE  (N_SENSE),
        .ADDR_W   (ADDR_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_i  (bus_addr_i),
        .we_i    (bus_we_i),
        .wdata_i (bus_wdata_i),
        .evt_i   (evt_vec),
        .rdata_o (bus_rdata_o),
        .sense_o (sense_vec),
        .mask_o  (mask_q),
        .flag_o  (flag_q)
    );

    assign pending_o = (flag_q | lvl_vec) & mask_q & {NUM_PINS{glb_en_i}};
    assign irq_o     = |pending_o;

endmodule

// File: rtl/ext_irq_sense_chk.sv
module ext_irq_sense_chk #(
    parameter int NUM_PINS = 8,
    parameter int ADDR_W   = 2,
    parameter logic [ADDR_W-1:0] FLAG_ADDR = '1
) (
    input logic                clk,
    input logic                rst_n,
    input logic                glb_en_i,
    input logic                bus_we_i,
    input logic [ADDR_W-1:0]   bus_addr_i,
    input logic [NUM_PINS-1:0] bus_wdata_i,
    input logic [NUM_PINS-1:0] mask_q,
    input logic [NUM_PINS-1:0] flag_q,
    input logic [NUM_PINS-1:0] evt_vec,
    input logic [NUM_PINS-1:0] pending_o,
    input logic                irq_o
);

    logic flag_wr;
    assign flag_wr = bus_we_i && (bus_addr_i == FLAG_ADDR);

    AST_IRQ_MATCHES_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (pending_o != '0)); // R12

    AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_en_i |-> (pending_o == '0 && !irq_o)); // R11

    AST_MASK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_o & ~mask_q) == '0); // R10

    AST_FLAG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        flag_wr |=> ((flag_q & $past(bus_wdata_i) & ~$past(evt_vec)) == '0)); // R8

    AST_FLAG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_wr && evt_vec == '0) |=> $stable(flag_q)); // R8

    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_vec != '0) |=> ((flag_q & $past(evt_vec)) == $past(evt_vec))); // R9

endmodule

bind ext_irq_sense ext_irq_sense_chk #(
    .NUM_PINS  (NUM_PINS),
    .ADDR_W    (ADDR_W),
    .FLAG_ADDR (FLAG_ADDR)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .glb_en_i    (glb_en_i),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .mask_q      (mask_q),
    .flag_q      (flag_q),
    .evt_vec     (evt_vec),
    .pending_o   (pending_o),
    .irq_o       (irq_o)
);

// File: tb/ext_irq_sense_bench.sv
`timescale 1ns/1ps
module ext_irq_sense_bench;

    localparam int KIND_IRQ  = 0;
    localparam int KIND_PEND = 1;
    localparam int KIND_READ = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pin = 8'hFF;
    logic       glb_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic       we = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [7:0] pending;
    logic       irq;

    typedef struct {
        int         kind;
        string      tag;
        logic [7:0] exp;
    } item_t;

    item_t exp_q[$];
    int    checks = 0;
    int    errors = 0;
    bit    done   = 1'b0;

    always #10 clk = ~clk;

    ext_irq_sense u_ext_irq_sense (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin_i       (pin),
        .glb_en_i    (glb_en),
        .bus_addr_i  (addr),
        .bus_we_i    (we),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .pending_o   (pending),
        .irq_o       (irq)
    );

    // Monitor: compares every queued expectation at the next falling edge
    initial begin
        forever begin
            @(negedge clk);
            while (exp_q.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it = exp_q.pop_front();
                case (it.kind)
                    KIND_IRQ:  act = {7'd0, irq};
                    KIND_PEND: act = pending;
                    default:   act = rdata;
                endcase
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual=%02h expected=%02h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic push(input int kind, input string tag, input logic [7:0] exp);
        item_t it;
        it.kind = kind;
        it.tag  = tag;
        it.exp  = exp;
        exp_q.push_back(it);
    endtask

    task automatic expect_read(input logic [1:0] a, input string tag, input logic [7:0] exp);
        addr = a;
        push(KIND_READ, tag, exp);
        step(1);
    endtask

    task automatic expect_out(input string tag, input logic [7:0] exp_pend, input logic exp_irq);
        push(KIND_PEND, tag, exp_pend);
        push(KIND_IRQ, tag, {7'd0, exp_irq});
        step(1);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        addr  = a;
        wdata = d;
        we    = 1'b1;
        step(1);
        we    = 1'b0;
        wdata = 8'h00;
    endtask

    initial begin
        #4000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        step(2);
        rst_n = 1'b1;
        step(1);

        // R1 reset state
        expect_out("R1 outputs idle", 8'h00, 1'b0);
        expect_read(2'd0, "R1 sense low reg", 8'h00);
        expect_read(2'd1, "R1 sense high reg", 8'h00);
        expect_read(2'd2, "R1 mask reg", 8'h00);
        expect_read(2'd3, "R1 flag reg", 8'h00);

        // R2 map: pin0 low, pin1 any, pin2 fall, pin3 rise; pin4 fall
        wr(2'd0, 8'hE4);
        wr(2'd1, 8'h02);
        wr(2'd2, 8'h0F);
        expect_read(2'd0, "R2 sense low readback", 8'hE4);
        expect_read(2'd1, "R2 sense high readback", 8'h02);
        expect_read(2'd2, "R2 mask readback", 8'h0F);
        glb_en = 1'b1;

        // R3 low level
        pin[0] = 1'b0;
        step(1);
        expect_out("R3 level asserts", 8'h01, 1'b1);
        expect_read(2'd3, "R3 no flag stored", 8'h00);
        pin[0] = 1'b1;
        step(1);
        expect_out("R3 level drops", 8'h00, 1'b0);

        // R7 and R5 falling edge timing
        pin[2] = 1'b0;
        step(1);
        push(KIND_PEND, "R7 not yet at two edges", 8'h00);
        step(1);
        push(KIND_PEND, "R7 flag at third edge", 8'h04);
        step(1);
        pin[2] = 1'b1;
        step(3);
        expect_read(2'd3, "R5 rise ignored in fall mode", 8'h04);
        wr(2'd3, 8'h04);
        expect_out("R8 flag cleared", 8'h00, 1'b0);

        // R5 one-period low pulse
        pin[2] = 1'b0;
        step(1);
        pin[2] = 1'b1;
        step(3);
        expect_read(2'd3, "R5 short pulse caught", 8'h04);
        wr(2'd3, 8'h04);

        // R6 rising edge
        pin[3] = 1'b0;
        step(3);
        expect_read(2'd3, "R6 fall ignored in rise mode", 8'h00);
        pin[3] = 1'b1;
        step(3);
        expect_read(2'd3, "R6 rise flagged", 8'h08);
        wr(2'd3, 8'h08);

        // R4 any change
        pin[1] = 1'b0;
        step(3);
        expect_read(2'd3, "R4 fall flagged", 8'h02);
        wr(2'd3, 8'h02);
        expect_read(2'd3, "R8 cleared after fall", 8'h00);
        pin[1] = 1'b1;
        step(3);
        expect_read(2'd3, "R4 rise flagged", 8'h02);
        wr(2'd3, 8'h00);
        expect_read(2'd3, "R8 zero write keeps flag", 8'h02);
        wr(2'd3, 8'h02);

        // R9 new edge coincides with clear
        pin[1] = 1'b0;
        step(3);
        pin[1] = 1'b1;
        step(2);
        wr(2'd3, 8'h02);
        expect_read(2'd3, "R9 set beats clear", 8'h02);
        wr(2'd3, 8'h02);
        expect_read(2'd3, "R9 later clear works", 8'h00);

        // R10 masked pin
        pin[4] = 1'b0;
        step(3);
        expect_out("R10 masked flag hidden", 8'h00, 1'b0);
        expect_read(2'd3, "R10 masked flag recorded", 8'h10);
        wr(2'd2, 8'h1F);
        expect_out("R10 unmasked flag shows", 8'h10, 1'b1);

        // R11 and R12 with two sources
        pin[0] = 1'b0;
        step(2);
        expect_out("R12 two sources", 8'h11, 1'b1);
        glb_en = 1'b0;
        expect_out("R11 global disable", 8'h00, 1'b0);
        glb_en = 1'b1;
        expect_out("R11 global re-enable", 8'h11, 1'b1);
        pin[0] = 1'b1;
        pin[4] = 1'b1;
        step(2);
        wr(2'd3, 8'h10);
        expect_out("R12 all quiet", 8'h00, 1'b0);

        step(2);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule